// File: doc/BRIEF.md
# Adaptive LMS Error Canceler

This block sits beside a primary FIR filter whose supply has been pushed below the point of reliable timing, so that its output now and then carries errors whose pattern depends on the input samples. The block keeps its own history of the same input samples. A short adaptive FIR over that history forms an estimate of the error, and the estimate is subtracted from the primary output. The samples used are the current one plus up to N_TAPS-1 earlier ones.

The weights are trained with a least-mean-square rule. During a power-up calibration, a known input sequence is played and a precomputed error-free output is supplied as the reference. Once the weights settle, the mode input is switched to run, and the corrected value appears at the output. Weight adaptation has its own enable, so it can be shut off to save energy or left on to follow slow drift. A static per-tap mask powers down the taps that contribute little. A weight stops moving by itself once its correction term falls below half a weight LSB. A flag reports when no active weight has moved for a programmable number of samples.

Top module: `aec_canceler`

## Requirements
- R1: A synchronous active-high reset clears all weights, the input history, y_out, out_valid and converged to zero.
- R2: Outputs are registered. out_valid in a cycle equals in_valid one cycle earlier. When in_valid is low, y_out, the weights, the history and the convergence count all hold.
- R3: With cal_mode=1, y_out becomes y_prim of the previous valid sample, uncorrected.
- R4: With cal_mode=0, y_out becomes sat16(y_prim - est), where est = sat16((sum over enabled taps k of w_k * x[n-k]) >>> 8). Tap 0 uses the current x_in, and a weight value of 256 stands for 1.0.
- R5: On a valid sample with adapt_en=1, e = sat16(sat16(y_prim - y_ref) - est). Each enabled weight becomes sat20(w_k + floor(e * x[n-k] / 2^s)).
- R6: A tap whose tap_mask bit is 0 adds nothing to est, and its weight does not change. With adapt_en=0, no weight changes and y_ref has no effect.
- R7: If |e * x[n-k]| < 2^(s-1), which is half a weight LSB after scaling, weight k keeps its value.
- R8: The step shift is s = mu_shift when mu_shift >= 4, and s = 4 otherwise. mu_shift is 4 bits, so s never exceeds 15.
- R9: converged rises after CONV_LEN consecutive valid samples with adapt_en=1 in which no weight changed value. It drops to 0 in the cycle after any weight changes.
- R10: The corrected output, the error term and the weights saturate at their signed limits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new input sample is present |
| x_in | input | 16 | Current input sample, signed |
| y_prim | input | 16 | Primary filter output for this sample, signed |
| y_ref | input | 16 | Error-free reference output, signed |
| cal_mode | input | 1 | 1 = calibration (pass primary output), 0 = run (cancel) |
| adapt_en | input | 1 | Enables weight updates |
| tap_mask | input | N_TAPS | Per-tap enable |
| mu_shift | input | 4 | Step size as a right shift |
| y_out | output | 16 | Corrected output, signed, one cycle later |
| out_valid | output | 1 | y_out was updated |
| converged | output | 1 | Weights have been still for CONV_LEN samples |

## Verification
A mixed table of calibration and run samples is replayed against an independent arithmetic model. This separates errors in the delay alignment, the scaling of the estimate and the sign of the update. A sample with tiny products distinguishes the half-LSB stop from plain truncation, and negative products show that the shift rounds toward minus infinity. Partial masks, a frozen adapt enable with a differing reference, a zero step shift and full-scale operands single out masking, freezing, shift clamping and saturation. A run of zero inputs times the convergence flag exactly at its threshold.

// File: rtl/aec_pkg.sv
package aec_pkg;
    localparam int DATA_W    = 16;
    localparam int WGT_W     = 20;
    localparam int WGT_FRAC  = 8;
    localparam int SHIFT_W   = 4;
    localparam int MIN_SHIFT = 4;
    localparam int ACC_W     = 48;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [WGT_W-1:0]  weight_t;

    typedef enum logic {MODE_RUN = 1'b0, MODE_CAL = 1'b1} mode_e;

    function automatic sample_t sat_sample(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi, lo;
        hi = (ACC_W'(1) <<< (DATA_W-1)) - 1;
        lo = -hi - 1;
        if (v > hi)      return sample_t'(hi);
        else if (v < lo) return sample_t'(lo);
        else             return sample_t'(v);
    endfunction

    function automatic weight_t sat_weight(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi, lo;
        hi = (ACC_W'(1) <<< (WGT_W-1)) - 1;
        lo = -hi - 1;
        if (v > hi)      return weight_t'(hi);
        else if (v < lo) return weight_t'(lo);
        else             return weight_t'(v);
    endfunction
endpackage

// File: rtl/aec_history.sv
module aec_history
    import aec_pkg::*;
#(
    parameter int N_TAPS = 8
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  sample_t x_in,
    output sample_t xv [N_TAPS]
);
    assign xv[0] = x_in;

    generate
        if (N_TAPS > 1) begin : g_line
            sample_t hist [N_TAPS-1];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < N_TAPS-1; j++) hist[j] <= '0;
                end else if (adv) begin
                    hist[0] <= x_in;
                    for (int j = 1; j < N_TAPS-1; j++) hist[j] <= hist[j-1];
                end
            end

            for (genvar k = 1; k < N_TAPS; k++) begin : g_out
                assign xv[k] = hist[k-1];
            end

            // R2: history advances only on valid samples
            p_shift_r2: assert property (@(posedge clk) disable iff (rst)
                adv |=> xv[1] == $past(x_in));
            p_hold_r2: assert property (@(posedge clk) disable iff (rst)
                !adv |=> $stable(xv[1]));
        end
    endgenerate
endmodule

// File: rtl/aec_tap.sv
module aec_tap
    import aec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  sample_t            err,
    input  sample_t            xk,
    input  logic [SHIFT_W-1:0] shift,
    output weight_t            w,
    output logic               changed
);
    logic signed [31:0]      prod;
    logic        [31:0]      mag;
    logic        [31:0]      half;
    logic signed [31:0]      step;
    logic signed [ACC_W-1:0] sum;
    weight_t                 nxt;
    logic                    big;

    assign prod = 32'(err) * 32'(xk);
    assign mag  = prod[31] ? 32'(-prod) : 32'(prod);
    assign half = 32'd1 << (shift - 4'd1);
    assign big  = (mag >= half);
    assign step = prod >>> shift;
    assign sum  = ACC_W'(w) + ACC_W'(step);
    assign nxt  = sat_weight(sum);
    assign changed = upd && big && (nxt != w);

    always_ff @(posedge clk) begin
        if (rst)             w <= '0;
        else if (upd && big) w <= nxt;
    end

    p_reset_r1: assert property (@(posedge clk) rst |=> w == '0);
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(w));
    p_zero_err_r7: assert property (@(posedge clk) disable iff (rst)
        (upd && err == '0) |=> $stable(w));
endmodule

// File: rtl/aec_estimate.sv
module aec_estimate
    import aec_pkg::*;
#(
    parameter int N_TAPS = 8
)(
    input  sample_t           xv   [N_TAPS],
    input  weight_t           w    [N_TAPS],
    input  logic [N_TAPS-1:0] mask,
    output sample_t           est
);
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < N_TAPS; k++) begin
            if (mask[k]) acc = acc + ACC_W'(xv[k]) * ACC_W'(w[k]);
        end
        est = sat_sample(acc >>> WGT_FRAC);
    end
endmodule

// File: rtl/aec_canceler.sv
module aec_canceler
    import aec_pkg::*;
#(
    parameter int N_TAPS   = 8,
    parameter int CONV_LEN = 64
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  x_in,
    input  logic signed [DATA_W-1:0]  y_prim,
    input  logic signed [DATA_W-1:0]  y_ref,
    input  logic                      cal_mode,
    input  logic                      adapt_en,
    input  logic [N_TAPS-1:0]         tap_mask,
    input  logic [SHIFT_W-1:0]        mu_shift,
    output logic signed [DATA_W-1:0]  y_out,
    output logic                      out_valid,
    output logic                      converged
);
    localparam int CNT_W = $clog2(CONV_LEN + 1);

    sample_t            xv  [N_TAPS];
    weight_t            wgt [N_TAPS];
    logic [N_TAPS-1:0]  chg;
    sample_t            est, target, err, corrected;
    logic [SHIFT_W-1:0] shift_eff;
    logic [CNT_W-1:0]   cnt;
    logic               any_change, learn;
    mode_e              mode;

    assign mode      = mode_e'(cal_mode);
    assign learn     = in_valid && adapt_en;
    assign shift_eff = (mu_shift < SHIFT_W'(MIN_SHIFT)) ? SHIFT_W'(MIN_SHIFT) : mu_shift;

    aec_history #(.N_TAPS(N_TAPS)) u_hist (
        .clk(clk), .rst(rst), .adv(in_valid), .x_in(x_in), .xv(xv)
    );

    aec_estimate #(.N_TAPS(N_TAPS)) u_est (
        .xv(xv), .w(wgt), .mask(tap_mask), .est(est)
    );

    assign target    = sat_sample(ACC_W'(y_prim) - ACC_W'(y_ref));
    assign err       = sat_sample(ACC_W'(target) - ACC_W'(est));
    assign corrected = sat_sample(ACC_W'(y_prim) - ACC_W'(est));

    generate
        for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
            aec_tap u_tap (
                .clk(clk), .rst(rst),
                .upd(learn && tap_mask[k]),
                .err(err), .xk(xv[k]), .shift(shift_eff),
                .w(wgt[k]), .changed(chg[k])
            );
        end
    endgenerate

    assign any_change = |chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            y_out     <= '0;
            out_valid <= 1'b0;
            cnt       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) y_out <= (mode == MODE_CAL) ? y_prim : corrected;
            if (learn) begin
                if (any_change)                 cnt <= '0;
                else if (cnt < CNT_W'(CONV_LEN)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign converged = (cnt == CNT_W'(CONV_LEN));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !out_valid && !converged));
    p_valid_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(y_out)));
    p_cal_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cal_mode) |=> y_out == $past(y_prim));
    p_conv_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (learn && any_change) |=> !converged);
    p_conv_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (converged && !(learn && any_change)) |=> converged);
endmodule

// File: tb/aec_canceler_tb.sv
`timescale 1ns/1ps
module aec_canceler_tb;
    localparam int NT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] x_in = '0, y_prim = '0, y_ref = '0;
    logic cal_mode = 1'b0, adapt_en = 1'b0;
    logic [NT-1:0] tap_mask = '1;
    logic [3:0] mu_shift = 4'd8;
    logic signed [15:0] y_out;
    logic out_valid, converged;

    always #2 clk = ~clk;

    aec_canceler #(.N_TAPS(NT), .CONV_LEN(64)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
        .y_prim(y_prim), .y_ref(y_ref), .cal_mode(cal_mode),
        .adapt_en(adapt_en), .tap_mask(tap_mask), .mu_shift(mu_shift),
        .y_out(y_out), .out_valid(out_valid), .converged(converged)
    );

    int nvec = 0, nfail = 0;

    // model state
    longint mw [NT];
    longint mh [NT];
    longint my_out;
    int     mcnt;
    bit     mvalid;

    typedef struct packed {
        logic signed [15:0] x;
        logic signed [15:0] yp;
        logic signed [15:0] yr;
        logic cal;
        logic adapt;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'sd100,  16'sd150,  16'sd100, 1'b1, 1'b1},
        '{-16'sd80,  16'sd40,   16'sd0,   1'b1, 1'b1},
        '{16'sd60,   -16'sd30,  16'sd10,  1'b1, 1'b1},
        '{16'sd200,  16'sd90,   16'sd20,  1'b1, 1'b1},
        '{-16'sd150, -16'sd60,  16'sd0,   1'b1, 1'b1},
        '{16'sd30,   16'sd25,   -16'sd5,  1'b1, 1'b1},
        '{16'sd120,  16'sd70,   16'sd30,  1'b0, 1'b0},
        '{-16'sd90,  -16'sd40,  16'sd0,   1'b0, 1'b0},
        '{16'sd50,   16'sd300,  16'sd0,   1'b0, 1'b1},
        '{16'sd0,    16'sd0,    16'sd0,   1'b0, 1'b0},
        '{-16'sd200, -16'sd100, 16'sd50,  1'b0, 1'b0},
        '{16'sd75,   16'sd10,   16'sd10,  1'b1, 1'b0}
    };

    function automatic longint sat(input longint v, input int bits);
        longint hi = (64'sd1 <<< (bits-1)) - 1;
        if (v > hi) return hi;
        if (v < -hi-1) return -hi-1;
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NT; k++) begin mw[k] = 0; mh[k] = 0; end
        my_out = 0; mcnt = 0; mvalid = 0;
    endtask

    task automatic check(input string req, input string what, input longint got, input longint exp);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // apply one sample, advance model, check after the edge
    task automatic step(input bit v, input longint x, input longint yp, input longint yr,
                        input bit cal, input bit adapt, input string req);
        longint xv [NT];
        longint acc, est, tgt, e, p, mag, s, nw;
        bit ch;
        in_valid = v; x_in = 16'(x); y_prim = 16'(yp); y_ref = 16'(yr);
        cal_mode = cal; adapt_en = adapt;
        xv[0] = x;
        for (int k = 1; k < NT; k++) xv[k] = mh[k-1];
        acc = 0;
        for (int k = 0; k < NT; k++) if (tap_mask[k]) acc += mw[k] * xv[k];
        est = sat(acc >>> 8, 16);
        s = (mu_shift < 4) ? 4 : longint'(mu_shift);
        ch = 0;
        if (v) begin
            my_out = cal ? yp : sat(yp - est, 16);
            if (adapt) begin
                tgt = sat(yp - yr, 16);
                e = sat(tgt - est, 16);
                for (int k = 0; k < NT; k++) begin
                    if (tap_mask[k]) begin
                        p = e * xv[k];
                        mag = (p < 0) ? -p : p;
                        if (mag >= (64'sd1 <<< (s-1))) begin
                            nw = sat(mw[k] + (p >>> s), 20);
                            if (nw != mw[k]) ch = 1;
                            mw[k] = nw;
                        end
                    end
                end
                if (ch) mcnt = 0;
                else if (mcnt < 64) mcnt++;
            end
            for (int k = NT-1; k > 0; k--) mh[k] = mh[k-1];
            mh[0] = x;
        end
        mvalid = v;
        @(posedge clk);
        @(negedge clk);
        check(req, "y_out", longint'(y_out), my_out);
        check(req, "out_valid", longint'(out_valid), longint'(mvalid));
        check(req, "converged", longint'(converged), longint'(mcnt == 64));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (all R): actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state
        check("R1", "y_out", longint'(y_out), 0);
        check("R1", "out_valid", longint'(out_valid), 0);
        check("R1", "converged", longint'(converged), 0);

        // R3 R4 R5: table walk, calibration then run
        tap_mask = '1; mu_shift = 4'd8;
        for (int i = 0; i < 12; i++)
            step(1'b1, longint'(VECS[i].x), longint'(VECS[i].yp), longint'(VECS[i].yr),
                 VECS[i].cal, VECS[i].adapt, "R4/R5 table");

        // R2: idle sample holds output, weights and history
        step(1'b0, 999, 999, 0, 1'b0, 1'b1, "R2 idle");
        step(1'b1, 40, 20, 0, 1'b0, 1'b0, "R2 after idle");

        // R6: partial mask, masked taps frozen and silent; adapt off ignores y_ref
        tap_mask = 8'h05;
        step(1'b1, 300, 200, 0, 1'b1, 1'b1, "R6 mask train");
        step(1'b1, -120, 50, 20, 1'b1, 1'b1, "R6 mask train");
        step(1'b1, 80, 100, -32000, 1'b0, 1'b0, "R6 adapt off");
        tap_mask = '1;
        step(1'b1, 80, 100, 32000, 1'b0, 1'b0, "R6 masked weights kept");

        // R7: half-LSB stop, then run shows weight still zero
        do_reset();
        tap_mask = 8'h01; mu_shift = 4'd8;
        step(1'b1, 1, 50, 0, 1'b1, 1'b1, "R7 tiny product");
        step(1'b1, 1, -100, 0, 1'b1, 1'b1, "R7 tiny negative");
        step(1'b1, 100, 0, 0, 1'b0, 1'b0, "R7 weight unchanged");
        check("R7", "y_out zero", longint'(y_out), 0);

        // R8: shift below 4 clamps; floor rounding of negative step
        mu_shift = 4'd0;
        step(1'b1, 1, 50, 0, 1'b1, 1'b1, "R8 clamp pos");
        step(1'b1, 1, -50, 0, 1'b1, 1'b1, "R8 clamp neg floor");
        step(1'b1, 256, 0, 0, 1'b0, 1'b0, "R8 read weight");

        // R10: saturation of weights and output
        do_reset();
        tap_mask = 8'h01; mu_shift = 4'd4;
        step(1'b1, 30000, 32767, -32768, 1'b1, 1'b1, "R10 weight sat");
        step(1'b1, 30000, 32767, -32768, 1'b1, 1'b1, "R10 weight sat");
        step(1'b1, 30000, -32768, 0, 1'b0, 1'b0, "R10 output sat");
        check("R10", "y_out floor", longint'(y_out), -32768);

        // R9: convergence after 64 quiet learning samples
        do_reset();
        tap_mask = '1; mu_shift = 4'd8;
        for (int i = 0; i < 66; i++) step(1'b1, 0, 0, 0, 1'b1, 1'b1, "R9 quiet");
        check("R9", "converged set", longint'(converged), 1);
        step(1'b1, 500, 300, 0, 1'b1, 1'b1, "R9 change clears");
        check("R9", "converged clear", longint'(converged), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule